// File: doc/BRIEF.md
# Security-Gated Privilege Configuration Register

This block holds one 32-bit configuration word in which four implemented bits each mark whether a peripheral slot demands privileged access. Bit 2 belongs to slot 0, bit 3 to slot 1, bit 4 to slot 2 and bit 13 to slot 3. Every other bit is reserved. A value of 1 means the slot needs privileged access, and 0 means unprivileged access is allowed. The per-slot values are also driven straight out on `priv_req` to the enforcement logic downstream.

The register sits on a plain register bus. Each transaction carries an address, write data, byte strobes, a secure attribute and a privileged attribute. The bus has no back-pressure: every write completes in the cycle it is presented and never returns an error. Whether a write may change a bit depends on the issuer's attributes and on that slot's effective security. Effective security is the OR of `slot_sec_cfg` and `slot_sec_forced`. A lock input freezes the whole word.

When a write is rejected and every slot is effectively secure, a one-cycle illegal-access pulse is raised. A rejected write under any other condition is dropped without any signal.

Top module: `privcfg_reg`

## Requirements
- R1: After reset, `bus_rdata` at the register offset reads 0x0000_0000, all `priv_req` bits are 0, and `illegal_evt` is 0.
- R2: Only bits 13, 4, 3 and 2 can be written. Every other bit always reads 0, whatever data is written.
- R3: A write with `bus_priv`=0 changes no bit.
- R4: For a slot whose effective security (`slot_sec_cfg[i] | slot_sec_forced[i]`) is 1, only a write with `bus_secure`=1 and `bus_priv`=1 can change that slot's bit.
- R5: For a slot whose effective security is 0, a privileged write changes that slot's bit whether `bus_secure` is 0 or 1.
- R6: With the address equal to the register offset (0x20), `bus_rdata` shows the current contents for every combination of `bus_secure` and `bus_priv`.
- R7: While `cfg_lock`=1, no write changes any bit.
- R8: A slot's bit is updated only if the strobe of its byte is set. Bit 13 needs `bus_wstrb[1]`, and bits 2 to 4 need `bus_wstrb[0]`. An accepted write shows on the read data after the clock edge that samples it.
- R9: A write is rejected if it hits the register and any of the following holds: the lock is set, `bus_priv` is 0, or a slot whose byte strobe is set is denied by R4. `illegal_evt` is 1 for exactly the cycle after a rejected write, and only if all four slots are effectively secure in the cycle of that write.
- R10: Writes to any other address change nothing and raise no event. Reads at any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Transaction select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes |
| bus_secure | input | 1 | Issuer secure attribute |
| bus_priv | input | 1 | Issuer privileged attribute |
| bus_rdata | output | 32 | Read data (combinational) |
| slot_sec_cfg | input | 4 | Per-slot security attribute |
| slot_sec_forced | input | 4 | Per-slot forced-secure option |
| cfg_lock | input | 1 | Freezes the register |
| priv_req | output | 4 | Per-slot privilege requirement |
| illegal_evt | output | 1 | One-cycle illegal-access pulse |

## Verification
The bench applies writes across the four attribute combinations under three security settings: all slots nonsecure, a mix of secure and nonsecure slots, and all slots secure. The mixed setting separates per-bit gating from whole-word gating. The all-secure setting is the only one in which rejections must pulse the event, so it checks that the event condition is right. Strobe-limited writes, locked writes and writes to other addresses confirm that each of these updates nothing. Reads under varying attributes, followed by a long random mix of attributes, strobes, lock and security vectors, are compared against a bench model.

// File: rtl/privcfg_pkg.sv
package privcfg_pkg;
  localparam int NSLOT  = 4;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  // bit position of each slot inside the word
  function automatic int slot_pos(input int i);
    case (i)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/privcfg_gate.sv
module privcfg_gate
  import privcfg_pkg::*;
(
  input  logic              wr_hit,
  input  logic              secure,
  input  logic              priv,
  input  logic              lock,
  input  logic [NSLOT-1:0]  eff_sec,
  input  logic [STRB_W-1:0] wstrb,
  output logic [NSLOT-1:0]  slot_we,
  output logic              wr_reject
);
  logic [NSLOT-1:0] allow;
  logic [NSLOT-1:0] strobed;
  logic             unused_strb;

  assign unused_strb = ^wstrb;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign strobed[i] = wstrb[slot_pos(i) / 8];
    assign allow[i]   = priv && !lock && (!eff_sec[i] || secure);
    assign slot_we[i] = wr_hit && allow[i] && strobed[i];
  end

  assign wr_reject = wr_hit && (lock || !priv || |(strobed & ~allow));
endmodule

// File: rtl/privcfg_bits.sv
module privcfg_bits
  import privcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_we,
  input  logic [NSLOT-1:0] slot_d,
  output logic [NSLOT-1:0] slot_q
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= 1'b0;
      else if (slot_we[i]) slot_q[i] <= slot_d[i];
    end

    // R8: a bit moves only when its enable was given
    assert_we_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[i] |=> $stable(slot_q[i]));
  end
endmodule

// File: rtl/privcfg_evt.sv
module privcfg_evt
  import privcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_reject,
  input  logic [NSLOT-1:0] eff_sec,
  output logic             illegal_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_evt <= 1'b0;
    else        illegal_evt <= wr_reject && (&eff_sec);
  end

  assert_evt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |-> ($past(wr_reject) && $past(&eff_sec)));
  assert_evt_when_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject && (&eff_sec)) |=> illegal_evt);
endmodule

// File: rtl/privcfg_reg.sv
module privcfg_reg
  import privcfg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_OFF = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_wstrb,
  input  logic              bus_secure,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSLOT-1:0]  slot_sec_cfg,
  input  logic [NSLOT-1:0]  slot_sec_forced,
  input  logic              cfg_lock,
  output logic [NSLOT-1:0]  priv_req,
  output logic              illegal_evt
);
  localparam logic [ADDR_W-1:0] OFF = REG_OFF[ADDR_W-1:0];

  logic              addr_hit;
  logic              wr_hit;
  logic [NSLOT-1:0]  eff_sec;
  logic [NSLOT-1:0]  slot_we;
  logic [NSLOT-1:0]  slot_d;
  logic [NSLOT-1:0]  slot_q;
  logic              wr_reject;
  logic [DATA_W-1:0] word;
  logic              unused_wdata;

  assign addr_hit     = (bus_addr == OFF);
  assign wr_hit       = bus_sel && bus_wr && addr_hit;
  assign eff_sec      = slot_sec_cfg | slot_sec_forced;
  assign unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < NSLOT; i++) begin : g_d
    assign slot_d[i] = bus_wdata[slot_pos(i)];

    // R4: a secure slot ignores nonsecure issuers
    assert_sec_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_sec[i] && !bus_secure) |=> $stable(slot_q[i]));
    // R8: strobe of the slot's byte must be set
    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !bus_wstrb[slot_pos(i) / 8]) |=> $stable(slot_q[i]));
  end

  privcfg_gate u_gate (
    .wr_hit    (wr_hit),
    .secure    (bus_secure),
    .priv      (bus_priv),
    .lock      (cfg_lock),
    .eff_sec   (eff_sec),
    .wstrb     (bus_wstrb),
    .slot_we   (slot_we),
    .wr_reject (wr_reject)
  );

  privcfg_bits u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_we (slot_we),
    .slot_d  (slot_d),
    .slot_q  (slot_q)
  );

  privcfg_evt u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_reject   (wr_reject),
    .eff_sec     (eff_sec),
    .illegal_evt (illegal_evt)
  );

  always_comb begin
    word = '0;
    for (int i = 0; i < NSLOT; i++) word[slot_pos(i)] = slot_q[i];
  end

  assign bus_rdata = addr_hit ? word : '0;
  assign priv_req  = slot_q;

  assert_unpriv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_priv) |=> $stable(slot_q));
  assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(slot_q));
  assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> ($stable(slot_q) && !illegal_evt));
endmodule

// File: tb/tb_privcfg_reg.sv
module tb_privcfg_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h20;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic        bus_secure = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  slot_sec_cfg = '0, slot_sec_forced = '0;
  logic        cfg_lock = 1'b0;
  logic [3:0]  priv_req;
  logic        illegal_evt;

  int n_vec = 0, n_bad = 0;
  logic [3:0] model = '0;

  always #2 clk = ~clk;

  privcfg_reg dut (.*);

  function automatic int pos(input int i);
    case (i) 0: return 2; 1: return 3; 2: return 4; default: return 13; endcase
  endfunction

  function automatic logic [31:0] word_of(input logic [3:0] m);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[pos(i)] = m[i];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] s, input logic sec, input logic pv);
    logic [3:0] es;
    logic hit, rej, ok;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    bus_secure = sec; bus_priv = pv;
    es = slot_sec_cfg | slot_sec_forced;
    hit = (a == 8'h20);
    rej = hit && (cfg_lock || !pv);
    for (int i = 0; i < 4; i++) begin
      ok = pv && !cfg_lock && (!es[i] || sec);
      if (hit && s[pos(i)/8]) begin
        if (ok) model[i] = d[pos(i)];
        else rej = 1'b1;
      end
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk({tag, " evt"}, {31'b0, illegal_evt}, {31'b0, rej && (&es)});
    bus_addr = 8'h20;
    #0.5;
    chk({tag, " data"}, bus_rdata, word_of(model));
    chk({tag, " priv_req"}, {28'b0, priv_req}, {28'b0, model});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 reset data", bus_rdata, 32'h0);
    chk("R1 reset evt", {31'b0, illegal_evt}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", bus_rdata, 32'h0);

    wr("R5 R2 ns priv all ones", 8'h20, 32'hFFFF_FFFF, 4'hF, 0, 1);
    chk("R2 reserved bits zero", bus_rdata, 32'h0000_201C);
    wr("R3 unpriv write", 8'h20, 32'h0, 4'hF, 1, 0);
    wr("R8 byte0 only", 8'h20, 32'h0, 4'h1, 1, 1);
    chk("R8 bit13 kept", bus_rdata, 32'h0000_2000);
    wr("R8 byte1 only", 8'h20, 32'hFFFF_FFFF, 4'h2, 0, 1);
    slot_sec_cfg = 4'b0101; slot_sec_forced = 4'b0010;
    wr("R4 mixed ns write", 8'h20, 32'h0000_001C, 4'h3, 0, 1);
    chk("R4 only slot3 cleared", bus_rdata, 32'h0000_0000);
    wr("R4 mixed sec write", 8'h20, 32'h0000_0014, 4'h1, 1, 1);
    slot_sec_forced = 4'b1010;
    wr("R9 all secure ns reject", 8'h20, 32'hFFFF_FFFF, 4'hF, 0, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, illegal_evt}, 32'h0);
    wr("R9 unpriv reject", 8'h20, 32'h0, 4'hF, 1, 0);
    wr("R4 secure priv ok", 8'h20, 32'h0000_2008, 4'h3, 1, 1);
    cfg_lock = 1;
    wr("R7 locked write", 8'h20, 32'h0, 4'hF, 1, 1);
    cfg_lock = 0;
    wr("R10 other address", 8'h24, 32'h0, 4'hF, 1, 1);
    bus_addr = 8'h24; #0.5;
    chk("R10 other read zero", bus_rdata, 32'h0);
    bus_addr = 8'h20;
    for (int k = 0; k < 4; k++) begin
      bus_secure = k[0]; bus_priv = k[1]; #0.5;
      chk("R6 read any attrs", bus_rdata, word_of(model));
    end

    for (int n = 0; n < 600; n++) begin
      if ($urandom % 8 == 0) begin
        slot_sec_cfg = 4'($urandom); slot_sec_forced = 4'($urandom);
      end
      cfg_lock = ($urandom % 8 == 0);
      wr("R9 R4 R5 random", ($urandom % 4 == 0) ? 8'h28 : 8'h20, $urandom,
         4'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule